// File: doc/BRIEF.md
# Serial EEPROM command controller

This block sits between a host register interface and a three-wire serial EEPROM with 128 byte-wide locations. The host writes a 32-bit command word whose top bit both starts an operation and reads back as a busy indicator. A 3-bit operation field and a 7-bit location sit in the same word. The block turns the command into a serial frame: chip select, serial clock, data to the device and data from the device. It returns read bytes in a separate 8-bit data register. Device programming operations end when the device reports ready on its data line. If the device never reports ready, a cycle-count time-out ends the operation.

Right after reset the block fetches a 48-bit station address from the EEPROM on its own. Busy stays set during this fetch, so the host sees one flag whether a host command, a reset-time fetch or a time-out is in progress. A signature byte at location 0 decides whether the fetched address is taken. The host can ask for the same fetch again with a dedicated operation code.

Top module: `eep_cmd_ctrl`

## Requirements
- R1: On the first clock after reset is released, busy (command bit 31) reads 1. It stays 1 until the station-address fetch has finished or given up.
- R2: If the byte at location 0 is 0xA5, the bytes at locations 1 to 6 are placed on `mac_addr`, location 1 in bits [7:0] up to location 6 in bits [47:40]. `mac_loaded` and command bit 9 become 1 in the same cycle that busy clears.
- R3: If the byte at location 0 is not 0xA5, busy still clears. `mac_loaded` reads 0 and `mac_addr` keeps its previous value.
- R4: A command write with bit 31 = 1 while busy is 0 starts the operation in bits [30:28] at the location in bits [6:0], and busy reads 1 on the next cycle. With bit 31 = 0 the write only updates those fields: busy stays 0 and chip select stays low.
- R5: Operation 000 (read) leaves the addressed byte in the data register once busy has cleared.
- R6: The device is changed only after operation 010 (write-enable) has been issued:
  - 011 stores the data-register byte at the location.
  - 101 sets the location to 0xFF.
  - 110 sets every location to 0xFF.
  - 100 stores the data-register byte at every location.
  - After 001 (write-disable), none of these change the device.
- R7: Chip select is high only while busy is 1, and the serial clock rises only while chip select is high. Each frame is sent MSB first with data to the device stable at every serial clock rising edge, in this order:
  - a start bit of 1;
  - a 2-bit opcode: read 10, write 011→01, erase 11, and 00 for the four whole-device/enable operations;
  - a 7-bit location, whose bits 6:5 are 11 for write-enable, 00 for write-disable, 10 for erase-all and 01 for write-all;
  - 8 data bits for the write and write-all operations.
- R8: After a programming frame (011, 100, 101, 110), chip select goes low, then high again. Busy stays 1 until the device drives its data line to 1. The time-out flag stays 0.
- R9: If the device does not report ready within `TIMEOUT_CYC` clock cycles, busy clears and command bit 8 (time-out) reads 1. The next started command clears it.
- R10: Host writes to the command or data register while busy is 1 have no effect. This includes the cycle in which a read completes.
- R11: Operation 111 reruns the station-address fetch, with busy held at 1 until it ends.
- R12: The command register reads back as follows:
  - bit 31: busy
  - bits 30:28: operation
  - bit 9: address loaded
  - bit 8: time-out
  - bits 6:0: location
  - all other bits: 0

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word written by the host |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | 8 | Byte written to the data register |
| cmd_rdata | output | 32 | Command register readback (busy, operation, flags, location) |
| data_rdata | output | 8 | Data register readback |
| mac_addr | output | 48 | Station address fetched from the EEPROM |
| mac_loaded | output | 1 | Station address fetch found a valid signature |
| eep_cs | output | 1 | EEPROM chip select |
| eep_sk | output | 1 | EEPROM serial clock |
| eep_si | output | 1 | Serial data to the EEPROM |
| eep_so | input | 1 | Serial data and ready status from the EEPROM |

## Verification
A host write to the data register and the return of read data can fall in the same clock edge: the one where the engine reports a read finished and busy is about to clear. The bench provokes this by holding the data-register write strobe high, with a marker value, for every cycle that busy reads 1 during a read. It releases the strobe only when busy is seen low. The collision is judged correct when the data register afterwards holds the EEPROM byte and not the marker. A command write held during another read is checked the same way: the location field must be unchanged and the device contents untouched.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int LOC_W  = 7;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_EWDS   = 3'd1,
    OP_EWEN   = 3'd2,
    OP_WRITE  = 3'd3,
    OP_WRAL   = 3'd4,
    OP_ERASE  = 3'd5,
    OP_ERAL   = 3'd6,
    OP_RELOAD = 3'd7
  } host_op_e;

  // One serial transaction as seen by the shift engine
  typedef struct packed {
    logic [1:0]       opc;
    logic [LOC_W-1:0] loc;
    logic             tx_byte;
    logic             rx_byte;
    logic             poll;
  } job_t;

  function automatic job_t make_job(host_op_e op, logic [LOC_W-1:0] a);
    job_t j;
    j.opc = 2'b00; j.loc = a; j.tx_byte = 1'b0; j.rx_byte = 1'b0; j.poll = 1'b0;
    case (op)
      OP_READ:  begin j.opc = 2'b10; j.rx_byte = 1'b1; end
      OP_WRITE: begin j.opc = 2'b01; j.tx_byte = 1'b1; j.poll = 1'b1; end
      OP_ERASE: begin j.opc = 2'b11; j.poll = 1'b1; end
      OP_EWEN:  j.loc = {2'b11, 5'd0};
      OP_EWDS:  j.loc = {2'b00, 5'd0};
      OP_WRAL:  begin j.loc = {2'b01, 5'd0}; j.tx_byte = 1'b1; j.poll = 1'b1; end
      OP_ERAL:  begin j.loc = {2'b10, 5'd0}; j.poll = 1'b1; end
      default:  ;
    endcase
    return j;
  endfunction
endpackage

// File: rtl/eep_tick_gen.sv
module eep_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == CW'(DIV - 1)) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/eep_serial_engine.sv
module eep_serial_engine
  import eep_pkg::*;
#(
  parameter int CLK_DIV     = 4,
  parameter int TIMEOUT_CYC = 6000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  job_t              job,
  input  logic [BYTE_W-1:0] wbyte,
  output logic              done,
  output logic [BYTE_W-1:0] rbyte,
  output logic              timed_out,
  output logic              cs,
  output logic              sk,
  output logic              si,
  input  logic              so
);
  localparam int HDR_W   = 3 + LOC_W;
  localparam int FRAME_W = HDR_W + BYTE_W;
  localparam int BW      = $clog2(FRAME_W + 1);
  localparam int TW      = $clog2(TIMEOUT_CYC + 1);

  typedef enum logic [2:0] {E_IDLE, E_SHIFT, E_CLOSE, E_GAP, E_POLL} eng_st_e;

  eng_st_e            st;
  job_t               job_q;
  logic [FRAME_W-1:0] tx;
  logic [BW-1:0]      bit_cnt;
  logic [BW-1:0]      last_bit;
  logic               ph;
  logic [TW-1:0]      tmo_cnt;
  logic               tick;

  eep_tick_gen #(.DIV(CLK_DIV)) u_tick (
    .clk (clk),
    .rst (rst),
    .en  (st != E_IDLE),
    .tick(tick)
  );

  always_comb
    last_bit = (job_q.tx_byte || job_q.rx_byte) ? BW'(FRAME_W - 1) : BW'(HDR_W - 1);

  always_ff @(posedge clk) begin
    done <= 1'b0;
    if (rst) begin
      st        <= E_IDLE;
      job_q     <= '0;
      tx        <= '0;
      bit_cnt   <= '0;
      ph        <= 1'b0;
      tmo_cnt   <= '0;
      rbyte     <= '0;
      timed_out <= 1'b0;
      cs        <= 1'b0;
      sk        <= 1'b0;
      si        <= 1'b0;
    end else begin
      case (st)
        E_IDLE: if (start) begin
          job_q     <= job;
          tx        <= {1'b1, job.opc, job.loc, wbyte};
          bit_cnt   <= '0;
          ph        <= 1'b0;
          cs        <= 1'b1;
          timed_out <= 1'b0;
          st        <= E_SHIFT;
        end
        E_SHIFT: if (tick) begin
          if (!ph) begin
            // low phase: present next bit, capture device bit
            sk <= 1'b0;
            si <= tx[FRAME_W-1];
            tx <= {tx[FRAME_W-2:0], 1'b0};
            if (job_q.rx_byte && bit_cnt >= BW'(HDR_W))
              rbyte <= {rbyte[BYTE_W-2:0], so};
            ph <= 1'b1;
          end else begin
            sk      <= 1'b1;
            ph      <= 1'b0;
            bit_cnt <= bit_cnt + 1'b1;
            if (bit_cnt == last_bit) st <= E_CLOSE;
          end
        end
        E_CLOSE: if (tick) begin
          sk <= 1'b0;
          si <= 1'b0;
          cs <= 1'b0;
          if (job_q.poll) st <= E_GAP;
          else begin
            done <= 1'b1;
            st   <= E_IDLE;
          end
        end
        E_GAP: if (tick) begin
          cs      <= 1'b1;
          tmo_cnt <= '0;
          st      <= E_POLL;
        end
        E_POLL: begin
          tmo_cnt <= tmo_cnt + 1'b1;
          if (tick && so) begin
            cs   <= 1'b0;
            done <= 1'b1;
            st   <= E_IDLE;
          end else if (tmo_cnt == TW'(TIMEOUT_CYC - 1)) begin
            cs        <= 1'b0;
            timed_out <= 1'b1;
            done      <= 1'b1;
            st        <= E_IDLE;
          end
        end
        default: st <= E_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/eep_cmd_ctrl.sv
module eep_cmd_ctrl
  import eep_pkg::*;
#(
  parameter int          CLK_DIV     = 4,
  parameter int          TIMEOUT_CYC = 6000000,
  parameter int          MAC_BYTES   = 6,
  parameter logic [7:0]  SIG_BYTE    = 8'hA5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cmd_wr,
  input  logic [31:0]            cmd_wdata,
  input  logic                   data_wr,
  input  logic [7:0]             data_wdata,
  output logic [31:0]            cmd_rdata,
  output logic [7:0]             data_rdata,
  output logic [8*MAC_BYTES-1:0] mac_addr,
  output logic                   mac_loaded,
  output logic                   eep_cs,
  output logic                   eep_sk,
  output logic                   eep_si,
  input  logic                   eep_so
);
  localparam int IW = $clog2(MAC_BYTES + 1);

  typedef enum logic [1:0] {M_IDLE, M_HOST, M_LOAD} mode_e;

  mode_e             mode;
  logic              busy_q, tmo_q, loaded_q;
  host_op_e          op_q;
  logic [LOC_W-1:0]  loc_q;
  logic [BYTE_W-1:0] data_q;
  logic [IW-1:0]     load_idx;
  job_t              job_q;
  logic              eng_start, eng_done, eng_tmo;
  logic [BYTE_W-1:0] eng_rbyte;
  logic [7:0]        mac_q [MAC_BYTES];
  logic              mac_we;
  host_op_e          wr_op;
  logic              unused_bits;

  assign wr_op       = host_op_e'(cmd_wdata[30:28]);
  assign unused_bits = ^cmd_wdata[27:7];

  eep_serial_engine #(.CLK_DIV(CLK_DIV), .TIMEOUT_CYC(TIMEOUT_CYC)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .start    (eng_start),
    .job      (job_q),
    .wbyte    (data_q),
    .done     (eng_done),
    .rbyte    (eng_rbyte),
    .timed_out(eng_tmo),
    .cs       (eep_cs),
    .sk       (eep_sk),
    .si       (eep_si),
    .so       (eep_so)
  );

  always_ff @(posedge clk) begin
    eng_start <= 1'b0;
    if (rst) begin
      mode      <= M_LOAD;
      busy_q    <= 1'b1;
      load_idx  <= '0;
      job_q     <= make_job(OP_READ, '0);
      eng_start <= 1'b1;
      loaded_q  <= 1'b0;
      tmo_q     <= 1'b0;
      op_q      <= OP_READ;
      loc_q     <= '0;
      data_q    <= '0;
    end else begin
      case (mode)
        M_IDLE: begin
          if (data_wr) data_q <= data_wdata;
          if (cmd_wr) begin
            op_q  <= wr_op;
            loc_q <= cmd_wdata[LOC_W-1:0];
            if (cmd_wdata[31]) begin
              busy_q    <= 1'b1;
              tmo_q     <= 1'b0;
              eng_start <= 1'b1;
              if (wr_op == OP_RELOAD) begin
                mode     <= M_LOAD;
                load_idx <= '0;
                job_q    <= make_job(OP_READ, '0);
              end else begin
                mode  <= M_HOST;
                job_q <= make_job(wr_op, cmd_wdata[LOC_W-1:0]);
              end
            end
          end
        end
        M_HOST: if (eng_done) begin
          busy_q <= 1'b0;
          tmo_q  <= eng_tmo;
          mode   <= M_IDLE;
          if (op_q == OP_READ) data_q <= eng_rbyte;
        end
        M_LOAD: if (eng_done) begin
          if (load_idx == '0) begin
            if (eng_rbyte == SIG_BYTE) begin
              load_idx  <= IW'(1);
              job_q     <= make_job(OP_READ, LOC_W'(1));
              eng_start <= 1'b1;
            end else begin
              loaded_q <= 1'b0;
              busy_q   <= 1'b0;
              mode     <= M_IDLE;
            end
          end else if (load_idx == IW'(MAC_BYTES)) begin
            loaded_q <= 1'b1;
            busy_q   <= 1'b0;
            mode     <= M_IDLE;
          end else begin
            load_idx  <= load_idx + 1'b1;
            job_q     <= make_job(OP_READ, LOC_W'(load_idx + 1'b1));
            eng_start <= 1'b1;
          end
        end
        default: mode <= M_IDLE;
      endcase
    end
  end

  // station address bytes: plain storage, no reset
  assign mac_we = (mode == M_LOAD) && eng_done && (load_idx != '0);

  always_ff @(posedge clk)
    if (mac_we) mac_q[load_idx - 1'b1] <= eng_rbyte;

  for (genvar g = 0; g < MAC_BYTES; g++) begin : g_mac
    assign mac_addr[g*8 +: 8] = mac_q[g];
  end

  assign cmd_rdata  = {busy_q, op_q, 18'd0, loaded_q, tmo_q, 1'b0, loc_q};
  assign data_rdata = data_q;
  assign mac_loaded = loaded_q;
endmodule

// File: rtl/eep_cmd_ctrl_chk.sv
module eep_cmd_ctrl_chk (
  input logic        clk,
  input logic        rst,
  input logic        cmd_wr,
  input logic        data_wr,
  input logic        eng_done,
  input logic [31:0] cmd_rdata,
  input logic [7:0]  data_rdata,
  input logic        eep_cs,
  input logic        eep_sk
);
  p_busy_after_reset_r1: assert property (@(posedge clk) rst |=> cmd_rdata[31]);

  p_cs_only_busy_r7: assert property (@(posedge clk) disable iff (rst)
    !cmd_rdata[31] |-> !eep_cs);

  p_sk_needs_cs_r7: assert property (@(posedge clk) disable iff (rst)
    !eep_cs |-> !eep_sk);

  p_busy_ends_on_done_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(cmd_rdata[31]) |-> $past(eng_done));

  p_cmd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_rdata[31] && cmd_wr) |=> $stable(cmd_rdata[30:0]) || $fell(cmd_rdata[31]));

  p_data_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_rdata[31] && data_wr && !eng_done) |=> $stable(data_rdata));

  p_tmo_at_end_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_rdata[8]) |-> $fell(cmd_rdata[31]));

  p_loaded_at_end_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_rdata[9]) |-> $fell(cmd_rdata[31]));
endmodule

bind eep_cmd_ctrl eep_cmd_ctrl_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_wr    (cmd_wr),
  .data_wr   (data_wr),
  .eng_done  (eng_done),
  .cmd_rdata (cmd_rdata),
  .data_rdata(data_rdata),
  .eep_cs    (eep_cs),
  .eep_sk    (eep_sk)
);

// File: tb/eep_cmd_ctrl_tb_top.sv
`timescale 1ns/1ps
module eep_cmd_ctrl_tb_top;
  localparam int TMO      = 2000;
  localparam int PROG_CLK = 300;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr = 1'b0;
  logic [31:0] cmd_wdata = '0;
  logic        data_wr = 1'b0;
  logic [7:0]  data_wdata = '0;
  logic [31:0] cmd_rdata;
  logic [7:0]  data_rdata;
  logic [47:0] mac_addr;
  logic        mac_loaded;
  logic        eep_cs, eep_sk, eep_si, eep_so;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  eep_cmd_ctrl #(.CLK_DIV(4), .TIMEOUT_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
    .data_wr(data_wr), .data_wdata(data_wdata), .cmd_rdata(cmd_rdata),
    .data_rdata(data_rdata), .mac_addr(mac_addr), .mac_loaded(mac_loaded),
    .eep_cs(eep_cs), .eep_sk(eep_sk), .eep_si(eep_si), .eep_so(eep_so)
  );

  // ---------------- behavioural serial EEPROM ----------------
  logic [7:0]  mem [128];
  logic        present = 1'b1;
  logic        we_en = 1'b0;
  logic        sk_q = 1'b0, cs_q = 1'b0;
  logic        ready_mode = 1'b0;
  int          prog_cnt = 0;
  int          nb = 0;
  logic [17:0] sr = '0;
  logic [7:0]  rd_sr = '0;
  logic        rd_act = 1'b0;
  int          bad_frames = 0;
  int          stray_sk = 0;
  logic [9:0]  hdr;
  logic [7:0]  dat;
  logic [9:0]  hdr_now;

  assign eep_so = present & ((rd_act & rd_sr[7]) | (ready_mode & eep_cs & (prog_cnt == 0)));

  always @(posedge clk) begin
    sk_q <= eep_sk;
    cs_q <= eep_cs;
    if (prog_cnt > 0) prog_cnt <= prog_cnt - 1;
    if (eep_sk && !sk_q && !eep_cs) stray_sk <= stray_sk + 1;
    if (eep_sk && !sk_q && eep_cs && !ready_mode) begin
      sr <= {sr[16:0], eep_si};
      nb <= nb + 1;
      if (nb == 0 && !eep_si) bad_frames <= bad_frames + 1;
      hdr_now = {sr[8:0], eep_si};
      if (nb == 9 && hdr_now[8:7] == 2'b10) begin
        rd_sr  <= mem[hdr_now[6:0]];
        rd_act <= 1'b1;
      end else if (nb >= 10 && rd_act) begin
        rd_sr <= {rd_sr[6:0], 1'b0};
      end
    end
    if (cs_q && !eep_cs) begin
      if (ready_mode) ready_mode <= 1'b0;
      else if (present) begin
        if (nb == 18) begin hdr = sr[17:8]; dat = sr[7:0]; end
        else begin hdr = sr[9:0]; dat = 8'h00; end
        case (hdr[8:7])
          2'b01: if (nb == 18) begin
            if (we_en) mem[hdr[6:0]] <= dat;
            prog_cnt <= we_en ? PROG_CLK : 0; ready_mode <= 1'b1;
          end
          2'b11: if (nb == 10) begin
            if (we_en) mem[hdr[6:0]] <= 8'hFF;
            prog_cnt <= we_en ? PROG_CLK : 0; ready_mode <= 1'b1;
          end
          2'b00: case (hdr[6:5])
            2'b11: we_en <= 1'b1;
            2'b00: we_en <= 1'b0;
            2'b10: if (nb == 10) begin
              if (we_en) for (int i = 0; i < 128; i++) mem[i] <= 8'hFF;
              prog_cnt <= we_en ? PROG_CLK : 0; ready_mode <= 1'b1;
            end
            default: if (nb == 18) begin
              if (we_en) for (int i = 0; i < 128; i++) mem[i] <= dat;
              prog_cnt <= we_en ? PROG_CLK : 0; ready_mode <= 1'b1;
            end
          endcase
          default: ;
        endcase
      end
      nb     <= 0;
      sr     <= '0;
      rd_act <= 1'b0;
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [7:0] init_byte(int i);
    return (i == 0) ? 8'hA5 : 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic host_cmd(input logic go, input logic [2:0] op, input logic [6:0] a);
    cmd_wdata = {go, op, 21'd0, a};
    cmd_wr    = 1'b1;
    @(negedge clk);
    cmd_wr    = 1'b0;
    cmd_wdata = '0;
  endtask

  task automatic wait_idle(output int cyc);
    cyc = 0;
    while (cmd_rdata[31] && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic set_data(input logic [7:0] v);
    data_wdata = v; data_wr = 1'b1;
    @(negedge clk);
    data_wr = 1'b0;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [6:0] a, output int cyc);
    host_cmd(1'b1, op, a);
    wait_idle(cyc);
  endtask

  logic [47:0] mac_exp;

  // ---------------- scenarios ----------------
  task automatic t_reset;
    int cyc;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after reset", cmd_rdata[31], 1);
    check("R1 data reg reset", data_rdata, 0);
    wait_idle(cyc);
    check("R1 busy clears after fetch", cmd_rdata[31], 0);
    for (int k = 0; k < 6; k++) mac_exp[k*8 +: 8] = init_byte(k + 1);
    check("R2 loaded flag", mac_loaded, 1);
    check("R2 station address", mac_addr, mac_exp);
    check("R12 loaded bit 9", cmd_rdata[9], 1);
  endtask

  task automatic t_field_write;
    host_cmd(1'b0, 3'b101, 7'h22);
    @(negedge clk);
    check("R4 no start without bit31", cmd_rdata[31], 0);
    check("R4 cs stays low", eep_cs, 0);
    check("R12 location field", cmd_rdata[6:0], 7'h22);
    check("R12 op field and zeros", {cmd_rdata[30:10], cmd_rdata[7]}, {3'b101, 19'd0});
  endtask

  task automatic t_read_collide(input logic [6:0] a);
    int guard = 0;
    host_cmd(1'b1, 3'b000, a);
    check("R4 busy after start", cmd_rdata[31], 1);
    while (cmd_rdata[31] && guard < 20000) begin
      data_wdata = 8'h3C; data_wr = 1'b1;
      @(negedge clk);
      guard++;
    end
    data_wr = 1'b0;
    check("R5 R10 read byte beats host write", data_rdata, init_byte(a));
  endtask

  task automatic t_busy_cmd_ignore;
    int cyc;
    host_cmd(1'b1, 3'b000, 7'd5);
    host_cmd(1'b1, 3'b110, 7'h55);
    wait_idle(cyc);
    check("R10 location kept", cmd_rdata[6:0], 7'd5);
    check("R10 op kept", cmd_rdata[30:28], 3'b000);
    check("R5 read loc 5", data_rdata, init_byte(5));
    run_op(3'b000, 7'd6, cyc);
    check("R10 ignored erase-all did not run", data_rdata, init_byte(6));
  endtask

  task automatic t_write_locked;
    int cyc;
    run_op(3'b001, 7'd0, cyc);
    set_data(8'h11);
    run_op(3'b011, 7'd3, cyc);
    run_op(3'b000, 7'd3, cyc);
    check("R6 write ignored when disabled", data_rdata, init_byte(3));
  endtask

  task automatic t_write_enabled;
    int cyc;
    run_op(3'b010, 7'd0, cyc);
    set_data(8'h11);
    run_op(3'b011, 7'd3, cyc);
    check("R8 busy covers device programming", cyc >= PROG_CLK, 1);
    check("R8 no time-out on ready", cmd_rdata[8], 0);
    run_op(3'b000, 7'd3, cyc);
    check("R6 written byte read back", data_rdata, 8'h11);
    run_op(3'b101, 7'd21, cyc);
    run_op(3'b000, 7'd21, cyc);
    check("R6 erase gives FF", data_rdata, 8'hFF);
  endtask

  task automatic t_reload;
    int cyc;
    host_cmd(1'b1, 3'b111, 7'd0);
    check("R11 busy during refetch", cmd_rdata[31], 1);
    wait_idle(cyc);
    mac_exp[23:16] = 8'h11;
    check("R11 refetched address", mac_addr, mac_exp);
    check("R11 loaded after refetch", mac_loaded, 1);
  endtask

  task automatic t_reload_invalid;
    int cyc;
    run_op(3'b110, 7'd0, cyc);
    run_op(3'b000, 7'd40, cyc);
    check("R6 erase-all gives FF", data_rdata, 8'hFF);
    run_op(3'b111, 7'd0, cyc);
    check("R3 busy clears", cmd_rdata[31], 0);
    check("R3 loaded cleared", mac_loaded, 0);
    check("R3 address kept", mac_addr, mac_exp);
  endtask

  task automatic t_timeout;
    int cyc;
    present = 1'b0;
    run_op(3'b011, 7'd4, cyc);
    check("R9 busy held to time-out", (cyc >= TMO) && (cyc < TMO + 600), 1);
    check("R9 time-out flag set", cmd_rdata[8], 1);
    run_op(3'b000, 7'd4, cyc);
    check("R9 flag cleared by next command", cmd_rdata[8], 0);
    present = 1'b1;
  endtask

  task automatic t_frames;
    check("R7 every frame began with start bit", bad_frames, 0);
    check("R7 no serial clock without select", stray_sk, 0);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = init_byte(i);
    @(negedge clk);
    t_reset();
    t_field_write();
    t_read_collide(7'd10);
    t_read_collide(7'd127);
    t_busy_cmd_ignore();
    t_write_locked();
    t_write_enabled();
    t_reload();
    t_reload_invalid();
    t_timeout();
    t_frames();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule